// File: doc/BRIEF.md
# Third-Order One-Bit Delta-Sigma Modulator

This block is a discrete-time, fixed-point model of a third-order noise-shaping loop. It has one output bit per clock. Every clock it takes a signed input sample and runs it through three cascaded integrators with feed-forward sums. A sign decision then picks a positive or a negative reference, and the next cycle subtracts that reference from the input. Over a long window, the density of ones in the output stream tracks where the input sits between the negative and the positive reference. A downstream decimator would turn that density back into multi-bit samples.

Each integrator scales its increment by a fixed gain of 0.15, held as a Q16 constant. The second integrator takes the output of the first. The third takes the sum of the first two. The comparator sees the sum of all three. All state is held in saturating accumulators, so an overdriven input pins them at the rails instead of wrapping them round.

A two-state controller sequences the loop. A synchronous reset puts it in `ST_PRIME` and loads the start values. The `PRIME_TO_RUN` transition takes it to `ST_RUN` on the first clock with reset low. It stays in `ST_RUN` (`RUN_HOLD`) until reset is asserted again (`ANY_TO_PRIME`).

Top module: `dsm3_modulator`

## Requirements
- R1: While `rst_i` is high at a clock edge, that edge loads integrator 1 with 2^(DW-2) and clears integrators 2 and 3, and `bit_o` reads 0 after the edge.
- R2: The first clock edge with `rst_i` low is a priming cycle. The integrators keep their start values and `bit_o` stays 0. Loop updates begin on the following edge.
- R3: The feedback value is +(2^(DW-1)-1) when the current `bit_o` is 1 and -(2^(DW-1)-1) when it is 0. It is subtracted from `sample_i` at the input of integrator 1.
- R4: Each integrator increment is floor(a * GAIN_Q / 2^GF), using an arithmetic right shift. The defaults are GAIN_Q = 9830 and GF = 16, which gives about 0.15.
- R5: Each running cycle computes, in this order: C1 += g(sample - fb), C2 += g(C1new), V2 = C2new + C1new, C3 += g(V2), V3 = V2 + C3new. Here g is the gain operation of R4.
- R6: In a running cycle, the next `bit_o` is 1 when V3 >= 0 and 0 otherwise. V3 is taken as an AW+1-bit sum, so it never saturates.
- R7: C1, C2, C3 and V2 saturate to the range [-2^(AW-1), 2^(AW-1)-1] and never wrap.
- R8: In steady state, the fraction of ones in `bit_o` is close to (1 + sample/(2^(DW-1)-1))/2, within 3 percent over 4000 cycles.
- R9: A reset asserted in the middle of a stream restores the R1 state and the R2 priming sequence, whatever the loop state was before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample-rate clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sample_i | input | DW | Signed two's-complement input sample |
| bit_o | output | 1 | Registered one-bit output stream |

## Verification
All of the loop state is hidden behind a single output bit. A wrong integrator value therefore shows up only when it flips the sign of V3, and that can be several clocks after the fault. Because of this, the output is compared on every clock against an independent model of the equations. That catches the first clock on which the stream diverges.

A fault in saturation stays hidden until an overdriven input pushes the accumulators to the rails. For that reason the bench builds the block with a narrower AW and overloads it for long enough that wrapping would reverse the output. The density checks then confirm that the bit stream still encodes its input level.

// File: rtl/dsm3_pkg.sv
package dsm3_pkg;

    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } dsm3_state_e;

    localparam int unsigned DSM3_GAIN_Q16 = 9830;

endpackage

// File: rtl/dsm3_ctrl.sv
module dsm3_ctrl
    import dsm3_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    output logic run_o
);

    dsm3_state_e state_q;
    dsm3_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        run_o = 1'b0;
        unique case (state_q)
            ST_PRIME: run_o = 1'b0;
            ST_RUN:   run_o = 1'b1;
            default:  run_o = 1'b0;
        endcase
    end

    // R2: the priming cycle always hands over to running
    assert_prime_to_run_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_PRIME) |=> (state_q == ST_RUN));

endmodule

// File: rtl/dsm3_integrator.sv
module dsm3_integrator #(
    parameter int                  AW    = 32,
    parameter int                  IW    = 17,
    parameter int                  GF    = 16,
    parameter int unsigned         GAIN  = 9830,
    parameter logic signed [AW-1:0] INIT = '0
) (
    input  logic                 clk_i,
    input  logic                 load_i,
    input  logic                 en_i,
    input  logic signed [IW-1:0] din_i,
    output logic signed [AW-1:0] q_o,
    output logic signed [AW-1:0] q_next_o
);

    localparam int GW = GF + 1;
    localparam int PW = IW + GW;
    localparam int SW = ((AW > PW) ? AW : PW) + 1;
    localparam logic signed [GW-1:0] GAIN_S = GW'(GAIN);
    localparam logic signed [SW-1:0] MAXX = {{(SW-AW+1){1'b0}}, {(AW-1){1'b1}}};
    localparam logic signed [SW-1:0] MINX = {{(SW-AW+1){1'b1}}, {(AW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] inc;
    logic signed [SW-1:0] qx;
    logic signed [SW-1:0] incx;
    logic signed [SW-1:0] sum;

    always_comb begin
        prod = PW'(din_i) * PW'(GAIN_S);
        inc  = prod >>> GF;
        qx   = {{(SW-AW){q_o[AW-1]}}, q_o};
        incx = {{(SW-PW){inc[PW-1]}}, inc};
        sum  = qx + incx;
        if (sum > MAXX) begin
            q_next_o = MAXX[AW-1:0];
        end else if (sum < MINX) begin
            q_next_o = MINX[AW-1:0];
        end else begin
            q_next_o = sum[AW-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (load_i) begin
            q_o <= INIT;
        end else if (en_i) begin
            q_o <= q_next_o;
        end
    end

    // R7: a non-negative increment never makes the accumulator smaller
    assert_no_wrap_up_R7: assert property (@(posedge clk_i) disable iff (load_i)
        (en_i && !inc[PW-1]) |=> (q_o >= $past(q_o)));

    // R7: a negative increment never makes the accumulator larger
    assert_no_wrap_down_R7: assert property (@(posedge clk_i) disable iff (load_i)
        (en_i && inc[PW-1]) |=> (q_o <= $past(q_o)));

    // R2: an idle stage keeps its value
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (load_i)
        (!en_i) |=> $stable(q_o));

endmodule

// File: rtl/dsm3_satadd.sv
module dsm3_satadd #(
    parameter int AW = 32
) (
    input  logic signed [AW-1:0] a_i,
    input  logic signed [AW-1:0] b_i,
    output logic signed [AW-1:0] y_o
);

    logic signed [AW:0] wide;

    always_comb begin
        wide = {a_i[AW-1], a_i} + {b_i[AW-1], b_i};
        if (wide[AW] != wide[AW-1]) begin
            y_o = wide[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
        end else begin
            y_o = wide[AW-1:0];
        end
    end

endmodule

// File: rtl/dsm3_quant.sv
module dsm3_quant #(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic                 clk_i,
    input  logic                 load_i,
    input  logic                 en_i,
    input  logic signed [AW-1:0] v2_i,
    input  logic signed [AW-1:0] c3_i,
    output logic                 bit_o,
    output logic signed [DW:0]   fb_o
);

    localparam logic signed [DW:0] REF_P = (DW+1)'((2 ** (DW-1)) - 1);
    localparam logic signed [DW:0] REF_N = -REF_P;

    logic signed [AW:0] v3;
    logic               v3_neg;

    always_comb begin
        v3     = {v2_i[AW-1], v2_i} + {c3_i[AW-1], c3_i};
        v3_neg = v3[AW];
        fb_o   = bit_o ? REF_P : REF_N;
    end

    always_ff @(posedge clk_i) begin
        if (load_i) begin
            bit_o <= 1'b0;
        end else if (en_i) begin
            bit_o <= ~v3_neg;
        end
    end

    // R6: a non-negative comparator input yields a one on the next clock
    assert_sign_one_R6: assert property (@(posedge clk_i) disable iff (load_i)
        (en_i && !v3_neg) |=> bit_o);

    // R6: a negative comparator input yields a zero on the next clock
    assert_sign_zero_R6: assert property (@(posedge clk_i) disable iff (load_i)
        (en_i && v3_neg) |=> !bit_o);

endmodule

// File: rtl/dsm3_modulator.sv
module dsm3_modulator #(
    parameter int          DW     = 16,
    parameter int          AW     = 32,
    parameter int          GF     = 16,
    parameter int unsigned GAIN_Q = dsm3_pkg::DSM3_GAIN_Q16
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic signed [DW-1:0] sample_i,
    output logic                 bit_o
);

    localparam int IW1 = DW + 1;
    localparam logic signed [AW-1:0] HALF = AW'(2 ** (DW-2));

    logic                 run;
    logic signed [DW:0]   fb;
    logic signed [IW1-1:0] err;
    logic signed [AW-1:0] c1_q, c1_n;
    logic signed [AW-1:0] c2_q, c2_n;
    logic signed [AW-1:0] c3_q, c3_n;
    logic signed [AW-1:0] v2;

    always_comb begin
        err = {sample_i[DW-1], sample_i} - fb;
    end

    dsm3_ctrl u_ctrl (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .run_o (run)
    );

    dsm3_integrator #(
        .AW(AW), .IW(IW1), .GF(GF), .GAIN(GAIN_Q), .INIT(HALF)
    ) u_int1 (
        .clk_i    (clk_i),
        .load_i   (rst_i),
        .en_i     (run),
        .din_i    (err),
        .q_o      (c1_q),
        .q_next_o (c1_n)
    );

    dsm3_integrator #(
        .AW(AW), .IW(AW), .GF(GF), .GAIN(GAIN_Q), .INIT('0)
    ) u_int2 (
        .clk_i    (clk_i),
        .load_i   (rst_i),
        .en_i     (run),
        .din_i    (c1_n),
        .q_o      (c2_q),
        .q_next_o (c2_n)
    );

    dsm3_satadd #(.AW(AW)) u_sum12 (
        .a_i (c2_n),
        .b_i (c1_n),
        .y_o (v2)
    );

    dsm3_integrator #(
        .AW(AW), .IW(AW), .GF(GF), .GAIN(GAIN_Q), .INIT('0)
    ) u_int3 (
        .clk_i    (clk_i),
        .load_i   (rst_i),
        .en_i     (run),
        .din_i    (v2),
        .q_o      (c3_q),
        .q_next_o (c3_n)
    );

    dsm3_quant #(.AW(AW), .DW(DW)) u_quant (
        .clk_i  (clk_i),
        .load_i (rst_i),
        .en_i   (run),
        .v2_i   (v2),
        .c3_i   (c3_n),
        .bit_o  (bit_o),
        .fb_o   (fb)
    );

    // R1: reset loads the start state
    assert_reset_state_R1: assert property (@(posedge clk_i)
        rst_i |=> (c1_q == HALF && c2_q == '0 && c3_q == '0 && !bit_o));

    // R2: the priming cycle leaves the loop untouched
    assert_prime_quiet_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !run |=> ($stable(c1_q) && $stable(c2_q) && $stable(c3_q) && !bit_o));

endmodule

// File: tb/dsm3_modulator_test.sv
module dsm3_modulator_test;

    localparam int DW = 16;
    localparam int AW = 24;
    localparam int GF = 16;
    localparam longint GQ   = 9830;
    localparam longint REFV = (longint'(1) << (DW-1)) - 1;
    localparam longint HALFV = longint'(1) << (DW-2);
    localparam longint AMAX = (longint'(1) << (AW-1)) - 1;
    localparam longint AMIN = -(longint'(1) << (AW-1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [DW-1:0] sample = '0;
    logic bit_out;

    int n_cmp = 0;
    int n_bad = 0;
    string req_tag = "R1";
    bit done = 1'b0;

    // model state
    longint m_c1, m_c2, m_c3;
    bit m_bit = 1'b0;
    bit m_run = 1'b0;
    bit m_valid = 1'b0;

    always #2 clk = ~clk;

    dsm3_modulator #(.DW(DW), .AW(AW), .GF(GF)) uut (
        .clk_i    (clk),
        .rst_i    (rst),
        .sample_i (sample),
        .bit_o    (bit_out)
    );

    function automatic longint clampv(longint v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    function automatic longint gainv(longint v);
        return (v * GQ) >>> GF;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_c1 = HALFV; m_c2 = 0; m_c3 = 0; m_bit = 1'b0;
            m_run = 1'b0; m_valid = 1'b1;
        end else if (!m_run) begin
            m_run = 1'b1;
        end else begin
            longint fbv, v2, v3;
            fbv  = m_bit ? REFV : -REFV;
            m_c1 = clampv(m_c1 + gainv(longint'(sample) - fbv));
            m_c2 = clampv(m_c2 + gainv(m_c1));
            v2   = clampv(m_c2 + m_c1);
            m_c3 = clampv(m_c3 + gainv(v2));
            v3   = v2 + m_c3;
            m_bit = (v3 >= 0);
        end
    end

    task automatic check(bit ok, string req, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model; R3 R4 R5 R6 R7 all show here
    always @(negedge clk) begin
        if (m_valid && !done) begin
            check(bit_out === m_bit, {req_tag, " per-clock bit_o"}, longint'(bit_out), longint'(m_bit));
        end
    end

    task automatic run_const(longint val, int n, bit dens, string req);
        int ones = 0;
        sample = DW'(val);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i >= 200 && bit_out) ones++;
        end
        if (dens) begin
            longint exp_pm, act_pm;
            act_pm = (longint'(ones) * 1000) / (n - 200);
            exp_pm = ((REFV + val) * 1000) / (2 * REFV);
            check((act_pm - exp_pm <= 30) && (exp_pm - act_pm <= 30), {req, " density per mille"}, act_pm, exp_pm);
        end
    endtask

    initial begin
        // R1: reset state
        req_tag = "R1";
        repeat (3) @(negedge clk);
        check(bit_out === 1'b0, "R1 reset bit_o", longint'(bit_out), 0);
        // R2: priming cycle
        req_tag = "R2";
        rst = 1'b0;
        sample = DW'(longint'(20000));
        @(negedge clk);
        check(bit_out === 1'b0, "R2 prime bit_o", longint'(bit_out), 0);
        req_tag = "R5";
        run_const(0, 4200, 1'b1, "R8 zero input");
        req_tag = "R3";
        run_const(9830, 4200, 1'b1, "R8 positive input");
        req_tag = "R4";
        run_const(-13107, 4200, 1'b1, "R8 negative input");
        req_tag = "R5";
        for (int k = 0; k < 2000; k++) begin
            sample = DW'(longint'((k * 37) % 16000) - 8000);
            @(negedge clk);
        end
        // R7: overload drives accumulators to the rails
        req_tag = "R7";
        run_const(-32768, 5000, 1'b0, "R7");
        run_const(0, 500, 1'b0, "R7");
        // R9: reset mid-stream restores start state and priming
        req_tag = "R9";
        rst = 1'b1;
        @(negedge clk);
        check(bit_out === 1'b0, "R9 reset bit_o", longint'(bit_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check(bit_out === 1'b0, "R9 prime bit_o", longint'(bit_out), 0);
        run_const(0, 4200, 1'b1, "R9 recovered density");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule